// File: doc/BRIEF.md
# Skip-Symbol Elastic Buffer

This block is a clock-compensation FIFO. It sits between a receive clock recovered from a serial line and the local core clock, which run at nearly but not exactly the same frequency. Every write cycle it can accept one decoded symbol, made of a data byte and a control flag. Once it is running, every read cycle it delivers one symbol. The two clocks may differ by up to ±5000 ppm. Over a long transfer the buffer would therefore drift toward full or empty. It prevents this by changing its occupancy with skip symbols only. Skip symbols are control characters with the flag set and the byte equal to 0x3C. Every other symbol passes through unchanged and in order.

On the write side, a skip symbol is thrown away instead of stored when the buffer looks too full. On the read side, a skip symbol that has just been delivered is delivered a second time when the buffer looks too empty. The write pointer and the read pointer each cross to the other clock as Gray code through a two-flop synchroniser. Each side then works out its own fill level from its own pointer and the synchronised copy of the other. Reading starts only after the fill level first reaches the midpoint. Two sticky flags report a write into a full buffer and a read from an empty one.

Top module: `clk_comp_fifo`

## Requirements
- R1: After reset, rd_valid, overflow and underflow are all low.
- R2: After reset, no symbol is delivered until the fill level seen by the read side first reaches 8. From then on rd_valid stays high in every read cycle, except in a cycle where the buffer is empty.
- R3: A non-skip symbol is passed to rd_ctrl/rd_data unchanged and in write order. A non-skip symbol is any pair other than flag 1 with byte 0x3C, so flag 1 with 0xBC and flag 0 with 0x3C are both non-skip. Such a symbol is never dropped or repeated, unless it was written while the buffer was full.
- R4: A skip symbol written while the fill level seen by the write side is above 10 is discarded and not stored. At 10 or below it is stored. A skip symbol discarded this way never raises overflow, even when the buffer is full.
- R5: When the symbol just delivered was a skip and the fill level seen by the read side is below 6, the read pointer holds for one cycle. The same skip symbol is then delivered again, with rd_valid high, at most once for each stored skip.
- R6: A delivered skip symbol is not repeated when the fill level seen by the read side is 6 or more.
- R7: A non-skip write arriving while the buffer holds 16 entries is not stored. It sets overflow, which stays high until wr_rst_n is asserted.
- R8: A read cycle that finds the buffer empty drives rd_valid low and sets underflow, which stays high until rd_rst_n is asserted.
- R9: The write clock runs 0.5% faster, or 0.5% slower, than the read clock, and a skip symbol is written as every sixth symbol. Over a stream of 1500 symbols the non-skip output sequence equals the non-skip input sequence, and neither flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock (write side) |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write side |
| wr_valid | input | 1 | A symbol is offered this write cycle |
| wr_ctrl | input | 1 | Control flag of the offered symbol |
| wr_data | input | 8 | Data byte of the offered symbol |
| rd_clk | input | 1 | Local core clock (read side) |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read side |
| rd_valid | output | 1 | A symbol is presented this read cycle |
| rd_ctrl | output | 1 | Control flag of the presented symbol |
| rd_data | output | 8 | Data byte of the presented symbol |
| overflow | output | 1 | Sticky: a non-skip symbol arrived while full (write domain) |
| underflow | output | 1 | Sticky: a read found the buffer empty (read domain) |

## Verification
Discarding a skip at the write side and repeating a skip at the read side can be active in the same stretch of time. Each side judges the fill level through a synchroniser that lags by a few cycles, so each sees a fill level skewed in its own safe direction. The bench provokes this by streaming long symbol runs with the write clock 0.5% fast and then 0.5% slow. The streams are judged by removing every skip from the output and requiring the rest to match the written payload exactly, with both flags still low. A second meeting point is a skip arriving at a full buffer, where discarding must win over overflow. The bench fills the buffer with the read side held in reset, offers a skip, and then checks that overflow is still low.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

   // Action chosen by the read side in one read cycle.
   typedef enum logic [1:0] {
      ACT_WAIT   = 2'd0,   // not yet started
      ACT_FETCH  = 2'd1,   // pop the oldest entry
      ACT_REPEAT = 2'd2,   // re-present the skip just delivered
      ACT_STARVE = 2'd3    // nothing stored: no output, flag it
   } rd_act_e;

endpackage

// File: rtl/ccf_ptr_sync.sv
// Carries a Gray-coded pointer into another clock domain through a
// flop chain and decodes it back to binary there.
module ccf_ptr_sync #(
   parameter int PW     = 5,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_in,
   output logic [PW-1:0] bin_out
);

   logic [PW-1:0] pipe_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[0] <= '0;
            else        pipe_q[0] <= gray_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[s] <= '0;
            else        pipe_q[s] <= pipe_q[s-1];
         end
      end
   end

   // Gray to binary: each binary bit is the parity of the Gray bits above it.
   for (genvar b = 0; b < PW; b++) begin : g_decode
      assign bin_out[b] = ^pipe_q[STAGES-1][PW-1:b];
   end

endmodule

// File: rtl/ccf_store.sv
// Symbol storage: written in the write domain, read asynchronously by address.
module ccf_store #(
   parameter int DEPTH = 16,
   parameter int SYM_W = 9,
   parameter int AW    = 4
) (
   input  logic             wr_clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [SYM_W-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [SYM_W-1:0] rdata
);

   logic [SYM_W-1:0] cell_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_cell
      always_ff @(posedge wr_clk) begin
         if (we && waddr == AW'(e)) cell_q[e] <= wdata;
      end
   end

   assign rdata = cell_q[raddr];

endmodule

// File: rtl/ccf_wr_ctrl.sv
// Write side: pointer, fill estimate, skip discard and overflow flag.
module ccf_wr_ctrl #(
   parameter int DEPTH   = 16,
   parameter int DATA_W  = 8,
   parameter int PW      = 5,
   parameter int HI_MARK = 10,
   parameter logic [DATA_W-1:0] SKIP_CODE = 'h3C
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              in_valid,
   input  logic              in_ctrl,
   input  logic [DATA_W-1:0] in_data,
   input  logic [PW-1:0]     rd_bin_sync,
   output logic              we,
   output logic [PW-2:0]     waddr,
   output logic [PW-1:0]     wr_gray,
   output logic [PW-1:0]     fill,
   output logic              overflow
);

   logic [PW-1:0] bin_q;
   logic [PW-1:0] bin_nx;
   logic [PW-1:0] gray_q;
   logic          ovf_q;
   logic          is_skip;
   logic          discard;
   logic          full;

   // The read pointer seen here is late, so the fill level can only be too high.
   assign fill    = bin_q - rd_bin_sync;
   assign is_skip = in_ctrl && (in_data == SKIP_CODE);
   assign discard = is_skip && (fill > PW'(HI_MARK));
   assign full    = (fill == PW'(DEPTH));
   assign we      = in_valid && !discard && !full;
   assign bin_nx  = bin_q + PW'(1);
   assign waddr   = bin_q[PW-2:0];

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (we) begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
         end
         if (in_valid && !discard && full) ovf_q <= 1'b1;
      end
   end

   assign wr_gray  = gray_q;
   assign overflow = ovf_q;

endmodule

// File: rtl/ccf_rd_ctrl.sv
// Read side: start-up gate, fetch, skip repeat and underflow flag.
module ccf_rd_ctrl
   import ccf_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int PW         = 5,
   parameter int LO_MARK    = 6,
   parameter int START_MARK = 8,
   parameter logic [DATA_W-1:0] SKIP_CODE = 'h3C
) (
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic [PW-1:0]     wr_bin_sync,
   input  logic [DATA_W:0]   rdata,
   output logic [PW-2:0]     raddr,
   output logic [PW-1:0]     rd_gray,
   output logic [PW-1:0]     rd_bin,
   output logic              out_valid,
   output logic              out_ctrl,
   output logic [DATA_W-1:0] out_data,
   output logic              underflow
);

   logic [PW-1:0] bin_q;
   logic [PW-1:0] bin_nx;
   logic [PW-1:0] gray_q;
   logic [PW-1:0] fill;
   logic          started_q;
   logic          last_skip_q;
   logic          repeated_q;
   logic          vld_q;
   logic          unf_q;
   logic [DATA_W:0] sym_q;
   logic          fetched_skip;
   rd_act_e       act;

   // The write pointer seen here is late, so the fill level can only be too low.
   assign fill         = wr_bin_sync - bin_q;
   assign fetched_skip = rdata[DATA_W] && (rdata[DATA_W-1:0] == SKIP_CODE);
   assign bin_nx       = bin_q + PW'(1);
   assign raddr        = bin_q[PW-2:0];

   always_comb begin
      if (!started_q)                                              act = ACT_WAIT;
      else if (last_skip_q && !repeated_q && fill < PW'(LO_MARK))  act = ACT_REPEAT;
      else if (fill == '0)                                         act = ACT_STARVE;
      else                                                         act = ACT_FETCH;
   end

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         bin_q       <= '0;
         gray_q      <= '0;
         started_q   <= 1'b0;
         last_skip_q <= 1'b0;
         repeated_q  <= 1'b0;
         vld_q       <= 1'b0;
         unf_q       <= 1'b0;
         sym_q       <= '0;
      end else begin
         if (!started_q && fill >= PW'(START_MARK)) started_q <= 1'b1;
         unique case (act)
            ACT_WAIT: vld_q <= 1'b0;
            ACT_REPEAT: begin
               vld_q      <= 1'b1;
               repeated_q <= 1'b1;
            end
            ACT_STARVE: begin
               vld_q       <= 1'b0;
               unf_q       <= 1'b1;
               last_skip_q <= 1'b0;
            end
            ACT_FETCH: begin
               vld_q       <= 1'b1;
               sym_q       <= rdata;
               bin_q       <= bin_nx;
               gray_q      <= bin_nx ^ (bin_nx >> 1);
               last_skip_q <= fetched_skip;
               repeated_q  <= 1'b0;
            end
            default: vld_q <= 1'b0;
         endcase
      end
   end

   assign rd_gray   = gray_q;
   assign rd_bin    = bin_q;
   assign out_valid = vld_q;
   assign out_ctrl  = sym_q[DATA_W];
   assign out_data  = sym_q[DATA_W-1:0];
   assign underflow = unf_q;

endmodule

// File: rtl/clk_comp_fifo.sv
// Dual-clock elastic buffer that keeps its level by discarding or repeating
// skip symbols only.
module clk_comp_fifo #(
   parameter int DEPTH       = 16,
   parameter int DATA_W      = 8,
   parameter int HI_MARK     = 10,
   parameter int LO_MARK     = 6,
   parameter int START_MARK  = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] SKIP_CODE = 'h3C
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_valid,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   output logic              rd_valid,
   output logic              rd_ctrl,
   output logic [DATA_W-1:0] rd_data,
   output logic              overflow,
   output logic              underflow
);

   localparam int AW    = $clog2(DEPTH);
   localparam int PW    = AW + 1;
   localparam int SYM_W = DATA_W + 1;

   // Elaboration-time parameter checks.
   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("clk_comp_fifo: DEPTH must be a power of two, at least 4");
   end
   if (!(LO_MARK < START_MARK && START_MARK < HI_MARK && HI_MARK < DEPTH)) begin : g_bad_marks
      $error("clk_comp_fifo: need LO_MARK < START_MARK < HI_MARK < DEPTH");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clk_comp_fifo: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("clk_comp_fifo: DATA_W must be at least 1");
   end

   logic [PW-1:0]    wr_gray_w;
   logic [PW-1:0]    rd_gray_w;
   logic [PW-1:0]    wr_bin_at_rd;
   logic [PW-1:0]    rd_bin_at_wr;
   logic [PW-1:0]    wr_fill_w;
   logic [PW-1:0]    rd_bin_w;
   logic             we_w;
   logic [AW-1:0]    waddr_w;
   logic [AW-1:0]    raddr_w;
   logic [SYM_W-1:0] rdata_w;

   ccf_wr_ctrl #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .PW(PW),
      .HI_MARK(HI_MARK), .SKIP_CODE(SKIP_CODE)
   ) u_wr (
      .wr_clk     (wr_clk),
      .wr_rst_n   (wr_rst_n),
      .in_valid   (wr_valid),
      .in_ctrl    (wr_ctrl),
      .in_data    (wr_data),
      .rd_bin_sync(rd_bin_at_wr),
      .we         (we_w),
      .waddr      (waddr_w),
      .wr_gray    (wr_gray_w),
      .fill       (wr_fill_w),
      .overflow   (overflow)
   );

   ccf_store #(.DEPTH(DEPTH), .SYM_W(SYM_W), .AW(AW)) u_store (
      .wr_clk(wr_clk),
      .we    (we_w),
      .waddr (waddr_w),
      .wdata ({wr_ctrl, wr_data}),
      .raddr (raddr_w),
      .rdata (rdata_w)
   );

   ccf_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_sync_to_rd (
      .clk    (rd_clk),
      .rst_n  (rd_rst_n),
      .gray_in(wr_gray_w),
      .bin_out(wr_bin_at_rd)
   );

   ccf_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_sync_to_wr (
      .clk    (wr_clk),
      .rst_n  (wr_rst_n),
      .gray_in(rd_gray_w),
      .bin_out(rd_bin_at_wr)
   );

   ccf_rd_ctrl #(
      .DATA_W(DATA_W), .PW(PW), .LO_MARK(LO_MARK),
      .START_MARK(START_MARK), .SKIP_CODE(SKIP_CODE)
   ) u_rd (
      .rd_clk     (rd_clk),
      .rd_rst_n   (rd_rst_n),
      .wr_bin_sync(wr_bin_at_rd),
      .rdata      (rdata_w),
      .raddr      (raddr_w),
      .rd_gray    (rd_gray_w),
      .rd_bin     (rd_bin_w),
      .out_valid  (rd_valid),
      .out_ctrl   (rd_ctrl),
      .out_data   (rd_data),
      .underflow  (underflow)
   );

endmodule

// File: rtl/ccf_checker.sv
// Temporal checks on clk_comp_fifo, attached with bind below.
module ccf_checker #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   parameter int PW     = 5,
   parameter logic [DATA_W-1:0] SKIP_CODE = 'h3C
) (
   input logic              wr_clk,
   input logic              wr_rst_n,
   input logic              wr_valid,
   input logic              wr_ctrl,
   input logic [DATA_W-1:0] wr_data,
   input logic [PW-1:0]     wr_fill,
   input logic              overflow,
   input logic              rd_clk,
   input logic              rd_rst_n,
   input logic              rd_valid,
   input logic              rd_ctrl,
   input logic [DATA_W-1:0] rd_data,
   input logic [PW-1:0]     rd_ptr,
   input logic              underflow
);

   // R7: overflow stays set until the write reset.
   a_r7_overflow_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      overflow |=> overflow);

   // R7: a non-skip write into a full buffer raises overflow.
   a_r7_full_write_flags: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_valid && !(wr_ctrl && wr_data == SKIP_CODE) && wr_fill == PW'(DEPTH)) |=> overflow);

   // R4: the write side never counts more entries than the storage holds.
   a_r4_fill_bounded: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_fill <= PW'(DEPTH));

   // R8: underflow stays set until the read reset.
   a_r8_underflow_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      underflow |=> underflow);

   // R8: the cycle that raises underflow shows no valid symbol.
   a_r8_underflow_no_valid: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $rose(underflow) |-> !rd_valid);

   // R2: once delivering, valid only drops on an empty buffer.
   a_r2_valid_drop_only_on_empty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $fell(rd_valid) |-> underflow);

   // R5: a valid symbol delivered without a pointer advance is a skip.
   a_r5_hold_emits_skip: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_valid && $past(rd_valid) && rd_ptr == $past(rd_ptr)) |-> (rd_ctrl && rd_data == SKIP_CODE));

endmodule

bind clk_comp_fifo ccf_checker #(
   .DEPTH(DEPTH), .DATA_W(DATA_W), .PW(PW), .SKIP_CODE(SKIP_CODE)
) u_ccf_chk (
   .wr_clk   (wr_clk),
   .wr_rst_n (wr_rst_n),
   .wr_valid (wr_valid),
   .wr_ctrl  (wr_ctrl),
   .wr_data  (wr_data),
   .wr_fill  (wr_fill_w),
   .overflow (overflow),
   .rd_clk   (rd_clk),
   .rd_rst_n (rd_rst_n),
   .rd_valid (rd_valid),
   .rd_ctrl  (rd_ctrl),
   .rd_data  (rd_data),
   .rd_ptr   (rd_bin_w),
   .underflow(underflow)
);

// File: tb/clk_comp_fifo_bench.sv
`timescale 1ns/1ps
module clk_comp_fifo_bench;

   logic       wr_clk = 1'b0;
   logic       rd_clk = 1'b0;
   logic       wr_rst_n = 1'b0;
   logic       rd_rst_n = 1'b0;
   logic       wr_valid = 1'b0;
   logic       wr_ctrl = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_valid, rd_ctrl, overflow, underflow;
   logic [7:0] rd_data;

   real wr_half = 5.0;
   int  n_checks = 0;
   int  n_fail = 0;
   int  cyc = 0;
   logic [8:0] got[$];

   localparam logic [8:0] SKP = {1'b1, 8'h3C};

   clk_comp_fifo u_clk_comp_fifo (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid),
      .wr_ctrl(wr_ctrl), .wr_data(wr_data),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
      .rd_ctrl(rd_ctrl), .rd_data(rd_data),
      .overflow(overflow), .underflow(underflow)
   );

   always #5.0 rd_clk = ~rd_clk;
   initial forever #(wr_half) wr_clk = ~wr_clk;

   // Output collector, sampled away from the read edge.
   always @(negedge rd_clk) if (rd_rst_n && rd_valid) got.push_back({rd_ctrl, rd_data});

   always @(posedge rd_clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cyc);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmp_seq(input string req, input logic [8:0] exp[$], input logic [8:0] act[$]);
      int bad = -1;
      check(act.size() == exp.size(), {req, " length"}, act.size(), exp.size());
      for (int i = 0; i < exp.size() && i < act.size(); i++)
         if (bad < 0 && act[i] !== exp[i]) bad = i;
      if (bad >= 0) check(1'b0, {req, " symbol"}, int'(act[bad]), int'(exp[bad]));
      else          check(1'b1, req, 0, 0);
   endtask

   task automatic do_reset(input bit hold_rd);
      wr_valid = 1'b0;
      wr_rst_n = 1'b0;
      rd_rst_n = 1'b0;
      repeat (4) @(negedge rd_clk);
      got.delete();
      @(negedge wr_clk) wr_rst_n = 1'b1;
      if (!hold_rd) @(negedge rd_clk) rd_rst_n = 1'b1;
      repeat (4) @(negedge rd_clk);
   endtask

   task automatic put(input logic [8:0] s);
      @(negedge wr_clk);
      wr_valid = 1'b1;
      {wr_ctrl, wr_data} = s;
   endtask

   task automatic quiet();
      @(negedge wr_clk) wr_valid = 1'b0;
   endtask

   task automatic release_rd();
      repeat (6) @(negedge wr_clk);
      @(negedge rd_clk) rd_rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
      check(overflow == 1'b0, "R1 overflow", overflow, 0);
      check(underflow == 1'b0, "R1 underflow", underflow, 0);
   endtask

   task automatic t_startup();
      logic [8:0] exp[$];
      do_reset(1'b0);
      for (int i = 0; i < 7; i++) begin put({1'b0, 8'h11 + 8'(i)}); exp.push_back({1'b0, 8'h11 + 8'(i)}); end
      quiet();
      repeat (20) @(negedge rd_clk);
      check(got.size() == 0, "R2 nothing before level 8", got.size(), 0);
      put({1'b0, 8'h18}); exp.push_back({1'b0, 8'h18});
      quiet();
      repeat (30) @(negedge rd_clk);
      cmp_seq("R2 R3 start at level 8", exp, got);
      check(underflow == 1'b1 && rd_valid == 1'b0, "R8 empty read", {underflow, rd_valid}, 2'b10);
   endtask

   task automatic t_discard();
      logic [8:0] exp[$];
      do_reset(1'b1);
      for (int i = 0; i < 10; i++) begin put({1'b0, 8'h20 + 8'(i)}); exp.push_back({1'b0, 8'h20 + 8'(i)}); end
      put(SKP); exp.push_back(SKP);           // level 10: stored
      put(SKP);                               // level 11: discarded
      put({1'b0, 8'h3C}); exp.push_back({1'b0, 8'h3C});
      put({1'b1, 8'hBC}); exp.push_back({1'b1, 8'hBC});
      put(SKP);                               // level 13: discarded
      quiet();
      release_rd();
      repeat (40) @(negedge rd_clk);
      // Skip delivered at level 2 after it, so it repeats (R5).
      exp.insert(11, SKP);
      cmp_seq("R4 R3 skip discard above 10", exp, got);
   endtask

   task automatic t_repeat();
      logic [8:0] exp[$];
      do_reset(1'b1);
      for (int i = 0; i < 7; i++) begin put({1'b0, 8'h40 + 8'(i)}); exp.push_back({1'b0, 8'h40 + 8'(i)}); end
      put(SKP); exp.push_back(SKP); exp.push_back(SKP);
      put({1'b0, 8'h47}); exp.push_back({1'b0, 8'h47});
      quiet();
      release_rd();
      repeat (30) @(negedge rd_clk);
      cmp_seq("R5 skip repeated once below 6", exp, got);
   endtask

   task automatic t_overflow();
      logic [8:0] exp[$];
      do_reset(1'b1);
      put({1'b0, 8'h60}); exp.push_back({1'b0, 8'h60});
      put({1'b0, 8'h61}); exp.push_back({1'b0, 8'h61});
      put(SKP); exp.push_back(SKP);
      for (int i = 2; i < 15; i++) begin put({1'b0, 8'h60 + 8'(i)}); exp.push_back({1'b0, 8'h60 + 8'(i)}); end
      put(SKP);                               // full: discarded, no overflow
      quiet();
      repeat (4) @(negedge wr_clk);
      check(overflow == 1'b0, "R4 skip at full leaves overflow low", overflow, 0);
      put({1'b0, 8'h6F});                     // full: lost, flagged
      quiet();
      repeat (3) @(negedge wr_clk);
      check(overflow == 1'b1, "R7 overflow on full write", overflow, 1);
      release_rd();
      repeat (40) @(negedge rd_clk);
      cmp_seq("R6 R7 no repeat at level 13, lost symbol absent", exp, got);
      check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
      repeat (20) @(negedge rd_clk);
      check(underflow == 1'b1, "R8 underflow sticky", underflow, 1);
   endtask

   task automatic t_stream(input real half, input string tag);
      logic [8:0] exp[$];
      logic [8:0] pay[$];
      int p = 0;
      wr_half = half;
      do_reset(1'b0);
      for (int i = 0; i < 1500; i++) begin
         if (i % 6 == 5) put(SKP);
         else begin
            logic [8:0] s;
            s = (p % 13 == 7) ? {1'b1, 8'hBC} : {1'b0, 8'(p)};
            put(s);
            exp.push_back(s);
            p++;
         end
      end
      for (int i = 0; i < 60; i++) put(SKP);
      foreach (got[k]) if (got[k] != SKP) pay.push_back(got[k]);
      cmp_seq({"R9 R3 payload intact ", tag}, exp, pay);
      check(overflow == 1'b0 && underflow == 1'b0, {"R9 no flags ", tag}, {overflow, underflow}, 0);
      quiet();
   endtask

   initial begin
      t_reset();
      t_startup();
      t_discard();
      t_repeat();
      t_overflow();
      t_stream(4.975, "writer fast");
      t_stream(5.025, "writer slow");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule